// File: doc/BRIEF.md
# DMA Graceful Stop and Interrupt Combiner

This block sits beside the DMA engine of an Ethernet controller. It handles orderly halts of the transmit and receive DMA paths. When software asks one direction to stop, the halt completes at once if that direction is idle. If a frame is still moving, the halt waits until the frame ends. Each completed halt raises a stop-done event.

The block also keeps the event register. Hardware sources set bits in it, and software clears them by writing ones. From these bits it drives three sticky interrupt lines: transmit, receive and error.

A third function is a self-rearming poll timer. While the wait bit in the DMA control word is clear, the timer asks the descriptor logic at a fixed interval to scan transmit ring 0. These requests are held back while a transmit stop is requested.

The register decode sits outside the block. It presents a DMA control write as a one-cycle `ctl_wr` strobe together with the written stop and wait bits. It presents an event-register write as `evt_clr_wr` together with the written data.

Top module: `dma_stop_irq_ctrl`

## Requirements
- R1: After reset, the event register reads 0, all three interrupt lines and both stopped flags are 0, and no poll pulse is seen.
- R2: A control write with the receive stop bit at 1 while `rx_busy` is 0 sets event bit 3 and `rx_stopped`, both visible in the cycle after the write.
- R3: A receive stop written while `rx_busy` is 1 leaves event bit 3 clear for as long as `rx_busy` stays 1. The bit is set in the cycle after the first cycle in which `rx_busy` is 0.
- R4: Transmit stop behaves as in R2 and R3, using `tx_busy`, event bit 2 and `tx_stopped`.
- R5: A control write with a stop bit at 0 cancels any deferred stop in that direction, so no stop-done event follows a later busy drop. The same write clears that direction's stopped flag.
- R6: The event bit map is as follows: bit 0 is transmit frame, bit 1 is receive frame, bit 2 is transmit stop done, bit 3 is receive stop done, and bits 4 to 15 are error-class sources. `evt_src` bits are set into the register one cycle later. An `evt_clr_wr` clears every bit written as 1. A bit that is set and cleared in the same cycle ends up set.
- R7: A line goes high in the cycle after an event of its class is set while that bit's `evt_mask` bit is 1. The classes are bit 0 for the transmit line, bit 1 for the receive line, and bits 2 to 15 for the error line. An event set while its mask bit is 0 is stored but raises no line.
- R8: After an event-register clear, a line drops only when no bit of its class remains set. The line stays high while another bit of its class remains.
- R9: A control write with the wait bit at 0 arms the poll timer. `poll_pulse` is then high for one cycle every POLL_CYCLES cycles. The first pulse comes POLL_CYCLES cycles after the write.
- R10: A control write with the wait bit at 1 stops the timer, and no further pulse follows.
- R11: While the transmit stop request is held at 1, expiries give no poll pulse.
- R12: A new control write with the wait bit at 0 restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | DMA control word write strobe |
| ctl_tx_stop | input | 1 | Written transmit stop request bit |
| ctl_rx_stop | input | 1 | Written receive stop request bit |
| ctl_wait | input | 1 | Written wait bit (1 = no polling) |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_busy | input | 1 | A receive frame is in progress |
| evt_src | input | 16 | One-cycle hardware event pulses |
| evt_clr_wr | input | 1 | Event register write strobe (write-1-to-clear) |
| evt_clr_data | input | 16 | Bits to clear |
| evt_mask | input | 16 | Interrupt enable for each event bit |
| evt_q | output | 16 | Event register contents |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_err | output | 1 | Error interrupt line |
| tx_stopped | output | 1 | Transmit path is halted |
| rx_stopped | output | 1 | Receive path is halted |
| poll_pulse | output | 1 | Request to scan transmit ring 0 |

## Verification
Stop requests are tried in four cases: each direction, with that direction idle and with it busy. This separates an immediate completion from a deferred one. A cancelled request is also tried, which shows that the deferred state is dropped rather than merely delayed.

Every event bit is set alone, once with its mask bit on and once with it off. This checks the class of each bit and the mask gating. Set and clear in the same cycle, and partial clears with several bits pending, tell the set-wins rule apart from a plain overwrite.

The poll timer is measured by the cycle distance between pulses. It is tried free-running, restarted in mid-count, blocked by a transmit stop request, and stopped by the wait bit.

// File: rtl/dma_stop_pkg.sv
package dma_stop_pkg;
  localparam int EVW = 16;
  localparam int EV_TXF   = 0;
  localparam int EV_RXF   = 1;
  localparam int EV_TSTOP = 2;
  localparam int EV_RSTOP = 3;
  localparam int NLINES   = 3;

  localparam logic [EVW-1:0] CLS_TX  = 16'h0001;
  localparam logic [EVW-1:0] CLS_RX  = 16'h0002;
  localparam logic [EVW-1:0] CLS_ERR = 16'hFFFC;

  // Next event register value: cleared bits drop, newly set bits win.
  function automatic logic [EVW-1:0] ev_update(input logic [EVW-1:0] q,
                                               input logic [EVW-1:0] clr,
                                               input logic [EVW-1:0] set);
    return (q & ~clr) | set;
  endfunction

  // Next level of a sticky line.
  function automatic logic line_update(input logic cur,
                                       input logic set_hit,
                                       input logic clr_wr,
                                       input logic remain);
    return set_hit | (cur & ~(clr_wr & ~remain));
  endfunction

  function automatic logic [EVW-1:0] class_of(input int idx);
    return (idx == 0) ? CLS_TX : (idx == 1) ? CLS_RX : CLS_ERR;
  endfunction
endpackage

// File: rtl/dma_stop_dir.sv
module dma_stop_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic req_bit,
  input  logic busy,
  output logic req_q,
  output logic stopped,
  output logic done
);
  logic pend_q;
  logic pend_n;

  always_comb begin
    done   = ~busy & (wr ? req_bit : pend_q);
    pend_n = wr ? (req_bit & busy) : (pend_q & busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      stopped <= 1'b0;
    end else begin
      pend_q <= pend_n;
      if (wr) req_q <= req_bit;
      if (wr && !req_bit) stopped <= 1'b0;
      else if (done)      stopped <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_stop_evt.sv
module dma_stop_evt
  import dma_stop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_wr,
  input  logic [EVW-1:0]      clr_data,
  input  logic [EVW-1:0]      set_vec,
  input  logic [EVW-1:0]      mask,
  output logic [EVW-1:0]      evt_q,
  output logic [NLINES-1:0]   irq_q
);
  logic [EVW-1:0] clr_eff;
  logic [EVW-1:0] evt_n;

  always_comb begin
    clr_eff = clr_wr ? clr_data : '0;
    evt_n   = ev_update(evt_q, clr_eff, set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_n;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    localparam logic [EVW-1:0] CLS = class_of(g);
    logic hit;
    logic remain;
    always_comb begin
      hit    = |(set_vec & mask & CLS);
      remain = |(evt_n & CLS);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= line_update(irq_q[g], hit, clr_wr, remain);
    end
  end
endmodule

// File: rtl/dma_stop_poll.sv
module dma_stop_poll #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wait_bit,
  input  logic hold,
  output logic expire,
  output logic pulse
);
  localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_comb expire = armed & ~wr & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= expire & ~hold;
      if (wr) begin
        armed <= ~wait_bit;
        cnt   <= '0;
      end else if (expire) begin
        cnt <= '0;
      end else if (armed) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_stop_irq_ctrl.sv
module dma_stop_irq_ctrl
  import dma_stop_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned POLL_US = 10_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic           ctl_tx_stop,
  input  logic           ctl_rx_stop,
  input  logic           ctl_wait,
  input  logic           tx_busy,
  input  logic           rx_busy,
  input  logic [15:0]    evt_src,
  input  logic           evt_clr_wr,
  input  logic [15:0]    evt_clr_data,
  input  logic [15:0]    evt_mask,
  output logic [15:0]    evt_q,
  output logic           irq_tx,
  output logic           irq_rx,
  output logic           irq_err,
  output logic           tx_stopped,
  output logic           rx_stopped,
  output logic           poll_pulse
);
  localparam int unsigned PER_US      = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int unsigned RAW_CYCLES  = PER_US * POLL_US;
  localparam int unsigned POLL_CYCLES = (RAW_CYCLES < 2) ? 2 : RAW_CYCLES;

  // direction 0 = transmit, 1 = receive
  logic [1:0] req_bits, busy_v, req_q, stopped_v, done_v;
  logic       tx_done, rx_done, tx_req, poll_expire;
  logic [EVW-1:0] set_vec;
  logic [NLINES-1:0] irq_v;

  assign req_bits = {ctl_rx_stop, ctl_tx_stop};
  assign busy_v   = {rx_busy, tx_busy};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    dma_stop_dir u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctl_wr),
      .req_bit (req_bits[d]),
      .busy    (busy_v[d]),
      .req_q   (req_q[d]),
      .stopped (stopped_v[d]),
      .done    (done_v[d])
    );
  end

  assign tx_done = done_v[0];
  assign rx_done = done_v[1];
  assign tx_req  = req_q[0];

  always_comb begin
    set_vec           = evt_src;
    set_vec[EV_TSTOP] = evt_src[EV_TSTOP] | tx_done;
    set_vec[EV_RSTOP] = evt_src[EV_RSTOP] | rx_done;
  end

  dma_stop_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (evt_clr_wr),
    .clr_data (evt_clr_data),
    .set_vec  (set_vec),
    .mask     (evt_mask),
    .evt_q    (evt_q),
    .irq_q    (irq_v)
  );

  dma_stop_poll #(.PERIOD(POLL_CYCLES)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wait_bit (ctl_wait),
    .hold     (tx_req),
    .expire   (poll_expire),
    .pulse    (poll_pulse)
  );

  assign irq_tx     = irq_v[0];
  assign irq_rx     = irq_v[1];
  assign irq_err    = irq_v[2];
  assign tx_stopped = stopped_v[0];
  assign rx_stopped = stopped_v[1];
endmodule

// File: rtl/dma_stop_irq_chk.sv
module dma_stop_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        ctl_rx_stop,
  input logic        ctl_wait,
  input logic        rx_busy,
  input logic [15:0] evt_src,
  input logic [15:0] evt_mask,
  input logic [15:0] evt_q,
  input logic        irq_tx,
  input logic        irq_err,
  input logic        rx_stopped,
  input logic        rx_done,
  input logic        poll_expire,
  input logic        poll_pulse
);
  assert_rx_stop_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_rx_stop && !rx_busy) |=> (evt_q[3] && rx_stopped));

  assert_rx_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done) |-> !rx_busy);

  assert_rx_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> evt_q[3]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_src != 16'h0) |=> ((evt_q & $past(evt_src)) == $past(evt_src)));

  assert_line_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_src[4] && evt_mask[4]) |=> irq_err);

  assert_tx_line_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> evt_q[0]);

  assert_err_line_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (evt_q[15:2] != 14'h0));

  assert_pulse_from_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    poll_pulse |-> $past(poll_expire));

  assert_wait_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wait) |=> (!poll_pulse && !poll_expire));
endmodule

bind dma_stop_irq_ctrl dma_stop_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr      (ctl_wr),
  .ctl_rx_stop (ctl_rx_stop),
  .ctl_wait    (ctl_wait),
  .rx_busy     (rx_busy),
  .evt_src     (evt_src),
  .evt_mask    (evt_mask),
  .evt_q       (evt_q),
  .irq_tx      (irq_tx),
  .irq_err     (irq_err),
  .rx_stopped  (rx_stopped),
  .rx_done     (rx_done),
  .poll_expire (poll_expire),
  .poll_pulse  (poll_pulse)
);

// File: tb/sim_dma_stop_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_stop_irq_ctrl;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_tx_stop = 0, ctl_rx_stop = 0, ctl_wait = 1;
  logic tx_busy = 0, rx_busy = 0;
  logic [15:0] evt_src = '0, evt_clr_data = '0, evt_mask = '0;
  logic evt_clr_wr = 0;
  logic [15:0] evt_q;
  logic irq_tx, irq_rx, irq_err, tx_stopped, rx_stopped, poll_pulse;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_stop_irq_ctrl #(.CLK_HZ(1_000_000), .POLL_US(P)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_tx_stop(ctl_tx_stop),
    .ctl_rx_stop(ctl_rx_stop), .ctl_wait(ctl_wait), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .evt_src(evt_src), .evt_clr_wr(evt_clr_wr),
    .evt_clr_data(evt_clr_data), .evt_mask(evt_mask), .evt_q(evt_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .tx_stopped(tx_stopped), .rx_stopped(rx_stopped), .poll_pulse(poll_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic tx, input logic rx, input logic wt);
    @(negedge clk);
    ctl_wr = 1; ctl_tx_stop = tx; ctl_rx_stop = rx; ctl_wait = wt;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic clr_evt(input logic [15:0] v);
    @(negedge clk);
    evt_clr_wr = 1; evt_clr_data = v;
    @(negedge clk);
    evt_clr_wr = 0; evt_clr_data = '0;
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    @(negedge clk);
    evt_src = v;
    @(negedge clk);
    evt_src = '0;
  endtask

  // counts pulses over n cycles, returns cycle index of first and second
  task automatic watch_poll(input int n, output int cnt, output int first, output int second);
    cnt = 0; first = -1; second = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (poll_pulse) begin
        cnt++;
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
  endtask

  // expected line levels for a single bit k with its mask m
  function automatic logic [2:0] exp_lines(input int k, input logic m);
    logic [2:0] r;
    r[0] = m && (k == 0);
    r[1] = m && (k == 1);
    r[2] = m && (k >= 2);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c, f, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(evt_q == 0 && !irq_tx && !irq_rx && !irq_err, "R1 evt/lines", evt_q, 0);
    chk(!tx_stopped && !rx_stopped, "R1 stopped", {tx_stopped, rx_stopped}, 0);
    watch_poll(3 * P, c, f, s);
    chk(c == 0, "R1 no poll", c, 0);

    evt_mask = 16'hFFFF;
    // R2 / R4 immediate, R3 / R4 deferred: sweep direction x busy
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] bitv;
        bitv = (d == 0) ? 16'h0004 : 16'h0008;
        if (d == 0) tx_busy = b[0]; else rx_busy = b[0];
        wr_ctl(d == 0, d == 1, 1'b1);
        if (b == 0) begin
          chk(evt_q == bitv, d == 0 ? "R4 tx stop now evt" : "R2 rx stop now evt", evt_q, bitv);
          chk((d == 0 ? tx_stopped : rx_stopped) == 1'b1, d == 0 ? "R4 tx stopped" : "R2 rx stopped", 0, 1);
          chk(irq_err == 1'b1, "R7 stop done raises err", irq_err, 1);
        end else begin
          repeat (4) @(negedge clk);
          chk(evt_q == 0, d == 0 ? "R4 tx deferred" : "R3 rx deferred", evt_q, 0);
          chk((d == 0 ? tx_stopped : rx_stopped) == 1'b0, d == 0 ? "R4 tx not yet" : "R3 rx not yet", 1, 0);
          if (d == 0) tx_busy = 0; else rx_busy = 0;
          @(negedge clk);
          chk(evt_q == bitv, d == 0 ? "R4 tx end of frame" : "R3 rx end of frame", evt_q, bitv);
          chk((d == 0 ? tx_stopped : rx_stopped) == 1'b1, d == 0 ? "R4 tx stopped late" : "R3 rx stopped late", 0, 1);
        end
        wr_ctl(1'b0, 1'b0, 1'b1);
        chk(!tx_stopped && !rx_stopped, "R5 release clears stopped", {tx_stopped, rx_stopped}, 0);
        clr_evt(16'hFFFF);
        chk(evt_q == 0 && !irq_err, "R8 all cleared", evt_q, 0);
      end
    end

    // R5 cancel of a deferred stop
    rx_busy = 1;
    wr_ctl(1'b0, 1'b1, 1'b1);
    wr_ctl(1'b0, 1'b0, 1'b1);
    rx_busy = 0;
    repeat (3) @(negedge clk);
    chk(evt_q == 0 && !rx_stopped, "R5 cancelled stop", evt_q, 0);

    // R6 R7 R8 single bit sweep, mask on and off
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [2:0] el;
        evt_mask = m[0] ? 16'hFFFF : 16'h0000;
        pulse_evt(16'h1 << k);
        el = exp_lines(k, m[0]);
        chk(evt_q == (16'h1 << k), "R6 bit set", evt_q, 16'h1 << k);
        chk({irq_err, irq_rx, irq_tx} == el, "R7 line class/mask", {irq_err, irq_rx, irq_tx}, el);
        clr_evt(16'h1 << k);
        chk(evt_q == 0 && {irq_err, irq_rx, irq_tx} == 0, "R8 drop after clear",
            {irq_err, irq_rx, irq_tx}, 0);
      end
    end

    // R6 set and clear in the same cycle
    evt_mask = 16'hFFFF;
    pulse_evt(16'h0040);
    @(negedge clk);
    evt_src = 16'h0020; evt_clr_wr = 1; evt_clr_data = 16'h0060;
    @(negedge clk);
    evt_src = '0; evt_clr_wr = 0; evt_clr_data = '0;
    chk(evt_q == 16'h0020, "R6 set wins over clear", evt_q, 16'h0020);
    clr_evt(16'hFFFF);

    // R8 partial clears
    pulse_evt(16'h0091);
    clr_evt(16'h0010);
    chk(irq_err && irq_tx, "R8 err stays with bit 7", {irq_err, irq_tx}, 3);
    clr_evt(16'h0080);
    chk(!irq_err && irq_tx, "R8 err drops, tx stays", {irq_err, irq_tx}, 1);
    clr_evt(16'h0001);
    chk(!irq_tx, "R8 tx drops", irq_tx, 0);

    // R9 free running poll
    wr_ctl(1'b0, 1'b0, 1'b0);
    watch_poll(2 * P, c, f, s);
    chk(f == P, "R9 first pulse", f, P);
    chk(s == 2 * P, "R9 second pulse", s, 2 * P);
    chk(c == 2, "R9 pulse count", c, 2);

    // R12 restart mid count
    wr_ctl(1'b0, 1'b0, 1'b0);
    repeat (P / 2) @(negedge clk);
    wr_ctl(1'b0, 1'b0, 1'b0);
    watch_poll(P, c, f, s);
    chk(f == P && c == 1, "R12 restart from zero", f, P);

    // R11 suppression while tx stop requested
    wr_ctl(1'b1, 1'b0, 1'b0);
    watch_poll(3 * P, c, f, s);
    chk(c == 0, "R11 suppressed", c, 0);
    wr_ctl(1'b0, 1'b0, 1'b0);
    watch_poll(P, c, f, s);
    chk(f == P, "R11 resumes", f, P);
    clr_evt(16'hFFFF);

    // R10 wait bit stops the timer
    wr_ctl(1'b0, 1'b0, 1'b1);
    watch_poll(3 * P, c, f, s);
    chk(c == 0, "R10 stopped", c, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule